// File: doc/BRIEF.md
# Two-Wire Bus Interrupt Control and Routing

This block holds the 8-bit interrupt control register of a two-wire serial bus controller, together with a small bus monitor. The monitor passes SCL and SDA through synchronizers and detects START and STOP conditions. From these it keeps a bus-busy status. When software sets the bus-free enable, a STOP latches a bus-free flag. Software can therefore wait for an idle bus without polling the busy status.

The module interrupt is the OR of the controller core's level transfer interrupt and the bus-free flag. It is steered by three independent enable bits to a CPU interrupt, a DMA transmit request and a DMA receive request. The bus-free flag does not clear by itself, because an idle bus stays idle. It drops only after software writes 0 to the bus-free enable. The register is accessed through a plain synchronous write strobe and a combinational read-data bus.

Top module: `twi_irq_ctrl`

## Requirements
- R1: Read data bits 7..4 always read 0, and writes to them are ignored. Bits 3..0 read back the last written value, with bit 3 = bus-free enable, bit 2 = DMA transmit routing, bit 1 = DMA receive routing and bit 0 = CPU routing.
- R2: After reset the register reads 0x01, and bus_busy, cpu_irq, dma_tx_req and dma_rx_req are 0 while the bus is idle and xfer_irq is 0.
- R3: A write with reg_we high takes effect at the rising clock edge and does not change the read data before it.
- R4: A START (SDA falling while SCL is high) sets bus_busy. A STOP (SDA rising while SCL is high) clears it.
- R5: SDA transitions while SCL is low neither set nor clear bus_busy.
- R6: A STOP sets the bus-free flag only while bit 3 is 1. Once set, the flag stays set while bit 3 remains 1, even if no further bus activity occurs.
- R7: The bus-free flag clears once bit 3 is 0, and it does not reappear when bit 3 is set again without a new STOP.
- R8: The module interrupt is xfer_irq OR the bus-free flag.
- R9: cpu_irq equals the module interrupt when bit 0 is 1, and is 0 otherwise.
- R10: dma_tx_req equals the module interrupt when bit 2 is 1, and is 0 otherwise.
- R11: dma_rx_req equals the module interrupt when bit 1 is 1, and is 0 otherwise.
- R12: bus_busy changes on the third rising clock edge after the SDA transition of a START or STOP (two synchronizer stages plus one edge-detect stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| xfer_irq | input | 1 | Level transfer interrupt from the controller core |
| bus_busy | output | 1 | Bus busy status |
| cpu_irq | output | 1 | Routed CPU interrupt |
| dma_tx_req | output | 1 | Routed DMA transmit request |
| dma_rx_req | output | 1 | Routed DMA receive request |

## Verification
The assertions assume that SCL and SDA never change in the same clock sample. A change of both at once could be read as a START or STOP, depending on synchronizer timing. The stimulus therefore moves one line at a time and holds each level for several cycles before the next change. The assertions also treat xfer_irq as a synchronous level, and the bench changes it only on the falling clock edge. Register writes are issued as single-cycle strobes, spaced apart from bus events, so the outputs can be checked one effect at a time.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;

  localparam int REG_W    = 8;
  localparam int CTRL_W   = 4;
  localparam int BIT_CPU  = 0;
  localparam int BIT_RX   = 1;
  localparam int BIT_TX   = 2;
  localparam int BIT_FREE = 3;

  typedef struct packed {
    logic free_en;
    logic tx_en;
    logic rx_en;
    logic cpu_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{free_en: 1'b0, tx_en: 1'b0, rx_en: 1'b0, cpu_en: 1'b1};

  typedef struct packed {
    logic tx;
    logic rx;
    logic cpu;
  } route_t;

  // Write data to control fields; upper bits dropped.
  function automatic ctrl_t decode_wr(input logic [REG_W-1:0] d);
    ctrl_t c;
    c.free_en = d[BIT_FREE];
    c.tx_en   = d[BIT_TX];
    c.rx_en   = d[BIT_RX];
    c.cpu_en  = d[BIT_CPU];
    return c;
  endfunction

  // Control fields to read data; reserved bits zero.
  function automatic logic [REG_W-1:0] encode_rd(input ctrl_t c);
    logic [REG_W-1:0] d;
    d = '0;
    d[BIT_FREE] = c.free_en;
    d[BIT_TX]   = c.tx_en;
    d[BIT_RX]   = c.rx_en;
    d[BIT_CPU]  = c.cpu_en;
    return d;
  endfunction

  function automatic route_t steer(input logic irq, input ctrl_t c);
    route_t r;
    r.tx  = irq & c.tx_en;
    r.rx  = irq & c.rx_en;
    r.cpu = irq & c.cpu_en;
    return r;
  endfunction

  // START: line high to low while clock held high across both samples.
  function automatic logic is_start(input logic scl_now, input logic scl_prev,
                                    input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & sda_prev & ~sda_now;
  endfunction

  function automatic logic is_stop(input logic scl_now, input logic scl_prev,
                                   input logic sda_now, input logic sda_prev);
    return scl_now & scl_prev & ~sda_prev & sda_now;
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/twi_bus_mon.sv
module twi_bus_mon
  import twi_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic busy
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_evt = is_start(scl_s, scl_p, sda_s, sda_p);
  assign stop_evt  = is_stop(scl_s, scl_p, sda_s, sda_p);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy <= 1'b0;
    else if (start_evt) busy <= 1'b1;
    else if (stop_evt)  busy <= 1'b0;
  end
endmodule

// File: rtl/twi_ctrl_reg.sv
module twi_ctrl_reg
  import twi_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl <= CTRL_RESET;
    else if (we) ctrl <= decode_wr(wdata);
  end

  assign rdata = encode_rd(ctrl);
endmodule

// File: rtl/twi_irq_route.sv
module twi_irq_route
  import twi_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  stop_evt,
  input  logic  xfer_irq,
  output logic  free_flag,
  output logic  mod_irq,
  output route_t route
);
  // Flag is held in clear while its enable is off; otherwise a STOP sets it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            free_flag <= 1'b0;
    else if (!ctrl.free_en) free_flag <= 1'b0;
    else if (stop_evt)     free_flag <= 1'b1;
  end

  assign mod_irq = xfer_irq | free_flag;
  assign route   = steer(mod_irq, ctrl);
endmodule

// File: rtl/twi_irq_ctrl.sv
module twi_irq_ctrl
  import twi_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             xfer_irq,
  output logic             bus_busy,
  output logic             cpu_irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  logic             scl_s, sda_s;
  logic             start_evt, stop_evt;
  logic             free_flag, mod_irq;
  ctrl_t            ctrl;
  route_t           route;

  twi_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .INIT('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twi_bus_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .busy(bus_busy)
  );

  twi_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .ctrl(ctrl), .rdata(reg_rdata)
  );

  twi_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .stop_evt(stop_evt),
    .xfer_irq(xfer_irq), .free_flag(free_flag), .mod_irq(mod_irq), .route(route)
  );

  assign cpu_irq    = route.cpu;
  assign dma_tx_req = route.tx;
  assign dma_rx_req = route.rx;
endmodule

// File: rtl/twi_irq_chk.sv
module twi_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       xfer_irq,
  input logic       bus_busy,
  input logic       cpu_irq,
  input logic       dma_tx_req,
  input logic       dma_rx_req,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       free_flag
);
  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:4] == 4'h0);
  // R3
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata[3:0] == $past(reg_wdata[3:0]));
  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_busy);
  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !bus_busy);
  // R4
  events_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt}));
  // R6
  free_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && reg_rdata[3]) |=> free_flag);
  // R6
  free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_flag && reg_rdata[3]) |=> free_flag);
  // R7
  free_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |=> !free_flag);
  // R6
  free_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(free_flag) |-> $past(stop_evt));
  // R9
  cpu_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (reg_rdata[0] && (xfer_irq || free_flag)));
  // R10
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tx_req |-> (reg_rdata[2] && (xfer_irq || free_flag)));
  // R11
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> (reg_rdata[1] && (xfer_irq || free_flag)));
  // R8
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && (xfer_irq || free_flag)) |-> cpu_irq);
endmodule

bind twi_irq_ctrl twi_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .xfer_irq(xfer_irq), .bus_busy(bus_busy),
  .cpu_irq(cpu_irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
  .start_evt(start_evt), .stop_evt(stop_evt), .free_flag(free_flag)
);

// File: tb/tb_twi_irq_ctrl.sv
`timescale 1ns/1ps
module tb_twi_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       xfer_irq = 1'b0;
  logic       bus_busy, cpu_irq, dma_tx_req, dma_rx_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  twi_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl_in), .sda_in(sda_in),
    .xfer_irq(xfer_irq), .bus_busy(bus_busy), .cpu_irq(cpu_irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  // {xfer, tx_en, rx_en, cpu_en, exp tx, exp rx, exp cpu}
  localparam logic [6:0] VEC [8] = '{
    7'b0_111_000, 7'b1_000_000, 7'b1_001_001, 7'b1_010_010,
    7'b1_100_100, 7'b1_111_111, 7'b0_101_000, 7'b1_110_110
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic line(input logic scl, input logic sda);
    @(negedge clk);
    scl_in = scl; sda_in = sda;
    cyc(4);
  endtask

  task automatic outs(input string req, input logic [2:0] exp);
    chk(req, {5'b0, dma_tx_req, dma_rx_req, cpu_irq}, {5'b0, exp});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R2
    chk("R2 reset value", reg_rdata, 8'h01);
    chk("R2 reset busy", {7'b0, bus_busy}, 8'h00);
    outs("R2 reset outputs", 3'b000);

    // R1: reserved bits ignored
    wr(8'hF0);
    chk("R1 reserved write", reg_rdata, 8'h00);
    wr(8'hFF);
    chk("R1 all ones", reg_rdata, 8'h0F);

    // R3: write lands at the edge, not before
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = 8'h05;
    #2;
    chk("R3 before edge", reg_rdata, 8'h0F);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R3 after edge", reg_rdata, 8'h05);

    // R9 R10 R11: routing table
    for (int i = 0; i < 8; i++) begin
      wr({5'b0, VEC[i][5:3]});
      xfer_irq = VEC[i][6];
      cyc(1);
      outs($sformatf("R9 R10 R11 vector %0d", i), VEC[i][2:0]);
    end
    xfer_irq = 1'b0;

    // R5: SDA moves while SCL low
    wr(8'h01);
    line(1'b0, 1'b1);
    line(1'b0, 1'b0);
    line(1'b1, 1'b0);
    chk("R5 no start with SCL low", {7'b0, bus_busy}, 8'h00);
    line(1'b0, 1'b0);
    line(1'b0, 1'b1);
    line(1'b1, 1'b1);
    chk("R5 still idle", {7'b0, bus_busy}, 8'h00);

    // R12 and R4: START latency
    @(negedge clk);
    sda_in = 1'b0;
    cyc(2);
    chk("R12 busy not yet", {7'b0, bus_busy}, 8'h00);
    cyc(1);
    chk("R12 R4 busy on third edge", {7'b0, bus_busy}, 8'h01);
    // STOP with bus-free disabled
    line(1'b1, 1'b1);
    chk("R4 stop clears busy", {7'b0, bus_busy}, 8'h00);
    outs("R6 no flag when disabled", 3'b000);

    // R6: flag with enable set
    wr(8'h09);
    line(1'b1, 1'b0);
    outs("R6 start does not set flag", 3'b000);
    line(1'b1, 1'b1);
    outs("R6 R8 stop raises cpu", 3'b001);
    cyc(20);
    outs("R6 flag persists", 3'b001);

    // R7: clear by writing 0 to bit 3
    wr(8'h01);
    cyc(1);
    outs("R7 flag cleared", 3'b000);
    wr(8'h09);
    cyc(2);
    outs("R7 no reappear", 3'b000);

    // R8 R10: flag routed to transmit request only
    wr(8'h0C);
    line(1'b1, 1'b0);
    line(1'b1, 1'b1);
    outs("R8 R10 flag to tx", 3'b100);
    xfer_irq = 1'b1;
    wr(8'h02);
    cyc(1);
    outs("R8 R11 xfer to rx", 3'b010);
    xfer_irq = 1'b0;
    cyc(1);
    outs("R8 xfer low", 3'b000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule